// File: doc/BRIEF.md
# Bidirectional Parity Transceiver with Error Latch

The block links an 8-bit A port to a 9-bit B port. The B port carries eight data bits and one parity bit. Two active-low enables choose the direction. With only the A-to-B enable low, the block drives B with the complemented A data and adds a parity bit that makes the 9-bit B word odd. With only the B-to-A enable low, it drives A with the complemented B data and checks the parity of all nine B bits. With both enables high, neither port is driven. With both enables low, the block sends A to B with the parity bit inverted. This deliberately corrupts the parity so that downstream error handling can be exercised.

A clocked flag register holds the result of the parity check. An active-low clear has the highest priority. A latch-enable input lets the flag follow the checker on every clock edge; with latch-enable low the flag keeps its value. The error output is modelled as an open-drain pin. It is a single pull-down enable that is asserted only while the flag is set. Each tri-state port is modelled as a separate output bus plus a drive-enable signal.

Top module: `parity_xcvr`

## Requirements
- R1: While `rst_n` is low, `a_drv`, `b_drv` and `err_pull` are 0. After reset is released, the flag starts cleared.
- R2: With `ab_en_n`=0 and `ba_en_n`=1, `b_drv`=1, `a_drv`=0 and `b_out[7:0]` equals the bitwise complement of `a_in`.
- R3: In the case of R2, `b_out[8]` is set so that the nine bits of `b_out` hold an odd number of ones.
- R4: With both enables 0, `b_drv`=1, `a_drv`=0 and `b_out[7:0]` equals the complement of `a_in`. `b_out[8]` is inverted relative to R3, so `b_out` holds an even number of ones.
- R5: With `ab_en_n`=1 and `ba_en_n`=0, `a_drv`=1, `b_drv`=0 and `a_out` equals the complement of `b_in[7:0]`.
- R6: With both enables 1, `a_drv`=0 and `b_drv`=0.
- R7: In the mode of R5, the checker reports an error when `b_in` holds an even number of ones. With `clr_n`=1 and `le`=1, the flag takes the checker result at the next rising clock edge, and `err_pull` equals the flag.
- R8: Whenever `ab_en_n`=0 or both enables are 1, the checker reports no error. With `le`=1 and `clr_n`=1, the flag becomes 0 at the next edge.
- R9: With `le`=0 and `clr_n`=1, the flag holds its value across the clock edge.
- R10: With `clr_n`=0, the flag becomes 0 at the next rising edge, whatever the value of `le`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the error flag register |
| rst_n | input | 1 | Asynchronous active-low reset |
| ab_en_n | input | 1 | Active-low enable for driving B from A |
| ba_en_n | input | 1 | Active-low enable for driving A from B |
| le | input | 1 | Flag update enable; when low the flag holds |
| clr_n | input | 1 | Active-low flag clear, highest priority |
| a_in | input | 8 | A port pad input |
| a_out | output | 8 | A port pad output value |
| a_drv | output | 1 | A port drive enable |
| b_in | input | 9 | B port pad input, bit 8 is parity |
| b_out | output | 9 | B port pad output value, bit 8 is parity |
| b_drv | output | 1 | B port drive enable |
| err_pull | output | 1 | Open-drain error pull-down enable, 1 pulls the pin low |

## Verification
The hardest situation to reach from the ports is a stored error that has to survive changes in direction. It must stay set while the forced-parity mode or the B-driving mode would otherwise clear it, and it must still give way to a clear even when latch-enable is high. The stimulus first loads an error through a B-to-A transfer with even-parity input. It then holds latch-enable low while it cycles through every enable combination, and finally asserts clear together with latch-enable. Random cycles with fixed-seed inputs cover many more mixes of mode, latch-enable and clear, and a bench model predicts the flag on each of them.

// File: rtl/parity_xcvr.sv
module parity_xcvr #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ab_en_n,
  input  logic          ba_en_n,
  input  logic          le,
  input  logic          clr_n,
  input  logic [DW-1:0] a_in,
  output logic [DW-1:0] a_out,
  output logic          a_drv,
  input  logic [DW:0]   b_in,
  output logic [DW:0]   b_out,
  output logic          b_drv,
  output logic          err_pull
);
  logic to_b, to_a, force_bad, chk_err, flag;
  logic [DW-1:0] a_inv;

  assign to_b      = rst_n && !ab_en_n;
  assign to_a      = rst_n && ab_en_n && !ba_en_n;
  assign force_bad = !ba_en_n;

  assign a_inv = ~a_in;
  assign b_out = {~(^a_inv) ^ force_bad, a_inv};
  assign b_drv = to_b;

  assign a_out = ~b_in[DW-1:0];
  assign a_drv = to_a;

  assign chk_err = to_a && !(^b_in);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      flag <= 1'b0;
    else if (!clr_n) flag <= 1'b0;
    else if (le)     flag <= chk_err;
  end

  assign err_pull = flag;
endmodule

// File: rtl/parity_xcvr_chk.sv
module parity_xcvr_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ab_en_n,
  input logic          ba_en_n,
  input logic          le,
  input logic          clr_n,
  input logic [DW-1:0] a_in,
  input logic [DW-1:0] a_out,
  input logic          a_drv,
  input logic [DW:0]   b_in,
  input logic [DW:0]   b_out,
  input logic          b_drv,
  input logic          err_pull
);
  a_r1_reset_quiet: assert property (@(posedge clk) !rst_n |-> !a_drv && !b_drv && !err_pull);

  a_r2_ab_dir: assert property (@(posedge clk) disable iff (!rst_n)
    (!ab_en_n && ba_en_n) |-> b_drv && !a_drv && b_out[DW-1:0] == ~a_in);

  a_r3_odd: assert property (@(posedge clk) disable iff (!rst_n)
    (b_drv && ba_en_n) |-> ($countones(b_out) % 2 == 1));

  a_r4_forced_even: assert property (@(posedge clk) disable iff (!rst_n)
    (b_drv && !ba_en_n) |-> ($countones(b_out) % 2 == 0));

  a_r5_ba_dir: assert property (@(posedge clk) disable iff (!rst_n)
    a_drv |-> !b_drv && a_out == ~b_in[DW-1:0]);

  a_r6_isolate: assert property (@(posedge clk) disable iff (!rst_n)
    (ab_en_n && ba_en_n) |-> !a_drv && !b_drv);

  a_r7_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (le && clr_n && ab_en_n && !ba_en_n) |=> err_pull == ($past($countones(b_in)) % 2 == 0));

  a_r8_no_check: assert property (@(posedge clk) disable iff (!rst_n)
    (le && clr_n && (!ab_en_n || ba_en_n)) |=> !err_pull);

  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!le && clr_n) |=> $stable(err_pull));

  a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_n |=> !err_pull);
endmodule

bind parity_xcvr parity_xcvr_chk #(.DW(DW)) u_chk (.*);

// File: tb/parity_xcvr_test.sv
module parity_xcvr_test;
  localparam int CLK_P = 10;

  logic clk = 0, rst_n = 0, ab_en_n = 1, ba_en_n = 1, le = 0, clr_n = 1;
  logic [7:0] a_in = 0, a_out;
  logic [8:0] b_in = 0, b_out;
  logic a_drv, b_drv, err_pull;
  int total = 0, bad = 0;
  logic mflag = 0;

  always #(CLK_P/2) clk = ~clk;

  parity_xcvr uut (.*);

  function automatic logic exp_chk(logic ab_n, logic ba_n, logic [8:0] b);
    return (ab_n && !ba_n) ? ($countones(b) % 2 == 0) : 1'b0;
  endfunction

  task automatic chk(string tag, logic [8:0] act, logic [8:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic check_comb();
    logic [8:0] bexp;
    bexp[7:0] = ~a_in;
    bexp[8] = ($countones(a_in) % 2 == 0) ^ !ba_en_n;
    bexp[8] = ~bexp[8];
    bexp[8] = ($countones(bexp[7:0]) % 2 == 0) ^ !ba_en_n;
    if (!ab_en_n) begin
      chk(ba_en_n ? "R2" : "R4", {7'b0, b_drv, a_drv}, 9'b10);
      chk(ba_en_n ? "R3" : "R4", b_out, bexp);
    end else if (!ba_en_n) begin
      chk("R5", {7'b0, b_drv, a_drv}, 9'b01);
      chk("R5", {1'b0, a_out}, {1'b0, ~b_in[7:0]});
    end else
      chk("R6", {7'b0, b_drv, a_drv}, 9'b00);
  endtask

  task automatic cyc(logic ab_n, logic ba_n, logic l, logic c, logic [7:0] a, logic [8:0] b);
    string tag;
    @(negedge clk);
    ab_en_n = ab_n; ba_en_n = ba_n; le = l; clr_n = c; a_in = a; b_in = b;
    #1 check_comb();
    if (!c) tag = "R10";
    else if (!l) tag = "R9";
    else if (!ab_n || ba_n) tag = "R8";
    else tag = "R7";
    if (!c) mflag = 0;
    else if (l) mflag = exp_chk(ab_n, ba_n, b);
    @(negedge clk);
    chk(tag, {8'b0, err_pull}, {8'b0, mflag});
  endtask

  initial begin
    #(CLK_P * 150000);
    bad++;
    $display("FAIL watchdog act=running exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    ab_en_n = 0; ba_en_n = 0; le = 1;
    #(CLK_P*2 + 1);
    chk("R1", {6'b0, a_drv, b_drv, err_pull}, 9'b0);
    @(negedge clk); rst_n = 1;
    #1 chk("R1", {8'b0, err_pull}, 9'b0);
    // load an error, then hold it through every mode (R9)
    cyc(1, 0, 1, 1, 8'h00, 9'h003);
    cyc(0, 1, 0, 1, 8'h5a, 9'h000);
    cyc(0, 0, 0, 1, 8'hff, 9'h000);
    cyc(1, 1, 0, 1, 8'h00, 9'h000);
    cyc(1, 0, 0, 1, 8'h00, 9'h001);
    // clear beats latch-enable (R10)
    cyc(1, 0, 1, 0, 8'h00, 9'h000);
    cyc(1, 0, 1, 1, 8'h00, 9'h1ff);
    cyc(0, 0, 1, 1, 8'h00, 9'h000);
    cyc(1, 0, 1, 1, 8'h00, 9'h000);
    cyc(1, 1, 1, 1, 8'h00, 9'h000);
    cyc(1, 0, 1, 1, 8'h81, 9'h100);
    cyc(0, 1, 1, 1, 8'h80, 9'h000);
    for (int i = 0; i < 2000; i++)
      cyc($urandom % 2, $urandom % 2, ($urandom % 4) != 0, ($urandom % 8) != 0,
          8'($urandom), 9'($urandom));
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule